// File: doc/BRIEF.md
# Three-Bus Datapath Load Sequencer

This block is a small processor datapath with three separate buses. Two source buses, A and B, feed an adder, and a result bus, C, is the only path back into the register file. The datapath holds eight general registers, an address register that drives the memory address, a data register that catches the word memory returns, a register that always holds zero, and an ALU output register. There is no wire from one bus to another, so anything that reaches a general register has been through the ALU.

A control sequencer runs one micro-operation sequence: load a word from memory into a chosen register. A command gives the address and the destination register index. The address register is loaded and drives a synchronous memory port. The sequencer then waits, for as long as it takes, until memory raises its ready flag. The returned word lands in the data register. The data register goes onto bus A and the zero register onto bus B. The ALU adds them, and the sum crosses bus C into the destination register. A one-cycle completion pulse follows. A read port onto the register file lets the surrounding logic observe any register.

Top module: `tribus_load_core`

## Requirements
- R1: While `rst_n` is low and right after it rises, every general register reads 0, `cmd_done` is 0 and `mem_req` is 0.
- R2: A `cmd_start` accepted while idle loads `cmd_addr` into the address register. On the next cycle `mem_req` is 1 and `mem_addr` equals that address. Both hold steady until the memory handshake completes.
- R3: The sequencer waits any number of cycles for `mem_ready`. The data register captures `mem_rdata` only in a cycle where `mem_req` and `mem_ready` are both 1. Memory data outside such a cycle never reaches a register.
- R4: The load passes through the ALU. Bus A carries the data register, bus B carries the zero register, and the ALU adds them. The sum is written over bus C into register `cmd_dst` (index 0 to 7). Any 16-bit value is preserved, including 0x0000, 0x0020 and 0xFFFF.
- R5: `cmd_done` is high for exactly one cycle. It rises on the second clock edge after the edge where `mem_ready` is accepted. If W is the number of wait cycles (at least 1), the start edge to the `cmd_done` edge spans 4+W edges counting both.
- R6: `cmd_start` is ignored unless the sequencer is idle. A request raised during a load changes no register and adds no extra `cmd_done` pulse.
- R7: A load writes only its destination register; the other seven keep their values.
- R8: `rd_data` shows register `rd_sel` combinationally, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cmd_start | input | 1 | Request a load (taken only when idle) |
| cmd_addr | input | 8 | Memory address of the load |
| cmd_dst | input | 3 | Destination register index |
| cmd_done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 8 | Memory address, driven by the address register |
| mem_ready | input | 1 | Memory output is valid |
| mem_rdata | input | 16 | Memory read data |
| rd_sel | input | 3 | Register file observation index |
| rd_data | output | 16 | Value of register `rd_sel` |

## Verification
The assertions assume that memory presents valid data in every cycle where it raises `mem_ready` with `mem_req` high. They also assume it keeps `mem_ready` low once `mem_req` drops. The bench memory model forms `mem_ready` only from the current request and a count of request cycles, and it returns garbage (0xDEAD) whenever ready is low. A capture at the wrong moment therefore corrupts the loaded value. Latencies from 0 to 6 cycles are swept across every destination register, with requests raised during busy loads.

// File: rtl/tribus_pkg.sv
package tribus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ADDR  = 3'd1,
    ST_WAIT  = 3'd2,
    ST_EXEC  = 3'd3,
    ST_WRITE = 3'd4
  } seq_state_e;

  typedef enum logic {
    ALU_PASS_A = 1'b0,
    ALU_ADD    = 1'b1
  } alu_op_e;

  typedef struct packed {
    logic    mar_ld;
    logic    mdr_ld;
    logic    mem_req;
    logic    a_from_mdr;
    logic    b_from_zero;
    alu_op_e alu_op;
    logic    alu_ld;
    logic    c_from_alu;
    logic    rf_we;
  } ctrl_t;

endpackage

// File: rtl/tribus_seq.sv
module tribus_seq
  import tribus_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  logic  mem_ready,
  output ctrl_t ctl,
  output logic  done
);

  seq_state_e state_q, state_d;
  logic       done_d;

  // next-state process
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start)     state_d = ST_ADDR;
      ST_ADDR:                 state_d = ST_WAIT;
      ST_WAIT:  if (mem_ready) state_d = ST_EXEC;
      ST_EXEC:                 state_d = ST_WRITE;
      ST_WRITE:                state_d = ST_IDLE;
      default:                 state_d = ST_IDLE;
    endcase
  end

  // control decode: one enable per bus source and per register
  always_comb begin
    ctl             = '0;
    ctl.alu_op      = ALU_PASS_A;
    ctl.mar_ld      = (state_q == ST_IDLE) && start;
    ctl.mem_req     = (state_q == ST_ADDR) || (state_q == ST_WAIT);
    ctl.mdr_ld      = (state_q == ST_WAIT) && mem_ready;
    if (state_q == ST_EXEC) begin
      ctl.a_from_mdr  = 1'b1;
      ctl.b_from_zero = 1'b1;
      ctl.alu_op      = ALU_ADD;
      ctl.alu_ld      = 1'b1;
    end
    if (state_q == ST_WRITE) begin
      ctl.c_from_alu = 1'b1;
      ctl.rf_we      = 1'b1;
    end
  end

  assign done_d = (state_q == ST_WRITE);

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      done    <= done_d;
    end
  end

endmodule

// File: rtl/tribus_alu.sv
module tribus_alu
  import tribus_pkg::*;
#(
  parameter int DW = 16
) (
  input  alu_op_e       op,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  output logic [DW-1:0] res
);

  always_comb begin
    unique case (op)
      ALU_ADD:    res = opa + opb;
      ALU_PASS_A: res = opa;
      default:    res = opa;
    endcase
  end

endmodule

// File: rtl/tribus_regfile.sv
module tribus_regfile #(
  parameter int DW   = 16,
  parameter int NREG = 8,
  localparam int SW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [SW-1:0] wsel,
  input  logic [DW-1:0] wdata,
  input  logic [SW-1:0] rsel,
  output logic [DW-1:0] rdata
);

  logic [NREG-1:0][DW-1:0] q_vec;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic          en;
    logic [DW-1:0] q;
    assign en = we && (wsel == SW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= wdata;
    end
    assign q_vec[i] = q;
  end

  assign rdata = q_vec[rsel];

endmodule

// File: rtl/tribus_load_core.sv
module tribus_load_core
  import tribus_pkg::*;
#(
  parameter int DW   = 16,
  parameter int AW   = 8,
  parameter int NREG = 8,
  localparam int SW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_start,
  input  logic [AW-1:0] cmd_addr,
  input  logic [SW-1:0] cmd_dst,
  output logic          cmd_done,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ready,
  input  logic [DW-1:0] mem_rdata,
  input  logic [SW-1:0] rd_sel,
  output logic [DW-1:0] rd_data
);

  ctrl_t         ctl;
  logic [AW-1:0] mar_q;
  logic [DW-1:0] mdr_q;
  logic [DW-1:0] zero_q;
  logic [DW-1:0] alu_q;
  logic [SW-1:0] dst_q;
  logic [DW-1:0] bus_a, bus_b, bus_c, alu_res;

  tribus_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (cmd_start),
    .mem_ready (mem_ready),
    .ctl       (ctl),
    .done      (cmd_done)
  );

  // address and destination registers, loaded when a command is taken
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mar_q <= '0;
      dst_q <= '0;
    end else if (ctl.mar_ld) begin
      mar_q <= cmd_addr;
      dst_q <= cmd_dst;
    end
  end

  // memory data register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          mdr_q <= '0;
    else if (ctl.mdr_ld) mdr_q <= mem_rdata;
  end

  // constant-zero register: cleared by reset, never loaded with anything else
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) zero_q <= '0;
    else        zero_q <= '0;
  end

  // source buses: each has a single enabled driver or floats to zero
  assign bus_a = ctl.a_from_mdr  ? mdr_q  : '0;
  assign bus_b = ctl.b_from_zero ? zero_q : '0;

  tribus_alu #(.DW(DW)) u_alu (
    .op  (ctl.alu_op),
    .opa (bus_a),
    .opb (bus_b),
    .res (alu_res)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          alu_q <= '0;
    else if (ctl.alu_ld) alu_q <= alu_res;
  end

  // result bus
  assign bus_c = ctl.c_from_alu ? alu_q : '0;

  tribus_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ctl.rf_we),
    .wsel  (dst_q),
    .wdata (bus_c),
    .rsel  (rd_sel),
    .rdata (rd_data)
  );

  assign mem_req  = ctl.mem_req;
  assign mem_addr = mar_q;

endmodule

// File: rtl/tribus_load_chk.sv
module tribus_load_chk #(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_ready,
  input logic [AW-1:0] mem_addr,
  input logic          cmd_done,
  input logic [DW-1:0] mdr,
  input logic [DW-1:0] bus_a,
  input logic [DW-1:0] bus_b,
  input logic [DW-1:0] bus_c,
  input logic          alu_ld,
  input logic          rf_we
);

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && $past(mem_req)) |-> $stable(mem_addr)); // R2

  AST_MDR_ON_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (mdr != $past(mdr)) |-> $past(mem_req && mem_ready)); // R3

  AST_ZERO_ON_B: assert property (@(posedge clk) disable iff (!rst_n)
    alu_ld |-> (bus_b == '0 && bus_a == mdr)); // R4

  AST_WB_AFTER_ALU: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> ($past(alu_ld) && bus_c == mdr)); // R4

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> !cmd_done); // R5

  AST_DONE_AFTER_WB: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |-> ($past(rf_we) && !mem_req)); // R5

endmodule

bind tribus_load_core tribus_load_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_req   (mem_req),
  .mem_ready (mem_ready),
  .mem_addr  (mem_addr),
  .cmd_done  (cmd_done),
  .mdr       (mdr_q),
  .bus_a     (bus_a),
  .bus_b     (bus_b),
  .bus_c     (bus_c),
  .alu_ld    (ctl.alu_ld),
  .rf_we     (ctl.rf_we)
);

// File: tb/tribus_load_core_test.sv
module tribus_load_core_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_start;
  logic [7:0]  cmd_addr;
  logic [2:0]  cmd_dst;
  logic        cmd_done;
  logic        mem_req;
  logic [7:0]  mem_addr;
  logic        mem_ready;
  logic [15:0] mem_rdata;
  logic [2:0]  rd_sel;
  logic [15:0] rd_data;

  int compared   = 0;
  int mismatched = 0;
  int lat_cfg    = 1;
  int req_cnt    = 0;
  bit finished   = 1'b0;
  logic [15:0] shadow [8];

  tribus_load_core uut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_addr(cmd_addr),
    .cmd_dst(cmd_dst), .cmd_done(cmd_done), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .rd_sel(rd_sel), .rd_data(rd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] memval(input int a);
    if (a == 3)   return 16'd32;
    if (a == 255) return 16'hFFFF;
    if (a == 128) return 16'h0000;
    return 16'((a * 1237) ^ 16'h5A5A);
  endfunction

  // memory model: ready after lat_cfg request cycles, garbage otherwise
  always @(posedge clk) begin
    if (!mem_req) req_cnt <= 0;
    else          req_cnt <= req_cnt + 1;
  end
  assign mem_ready = mem_req && (req_cnt >= lat_cfg);
  assign mem_rdata = mem_ready ? memval(int'(mem_addr)) : 16'hDEAD;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_regs(input string req);
    for (int r = 0; r < 8; r++) begin
      rd_sel = 3'(r);
      #1;
      chk(rd_data === shadow[r], req, 32'(rd_data), 32'(shadow[r]));
    end
  endtask

  task automatic run_load(input int a, input int d, input int lat, input bit poke);
    int n;
    int w;
    lat_cfg = lat;
    w = (lat < 1) ? 1 : lat;
    @(negedge clk);
    cmd_start = 1'b1; cmd_addr = 8'(a); cmd_dst = 3'(d);
    @(negedge clk);
    n = 1;
    chk(mem_req === 1'b1 && mem_addr === 8'(a), "R2 request/address",
        {23'd0, mem_req, mem_addr}, {23'd0, 1'b1, 8'(a)});
    if (poke) begin
      cmd_addr = 8'(a ^ 8'h55); cmd_dst = 3'(d ^ 1); // R6 busy request
    end else begin
      cmd_start = 1'b0;
    end
    while (!cmd_done && n < 60) begin
      if (mem_req)
        chk(mem_addr === 8'(a), "R2 address hold", 32'(mem_addr), 32'(a));
      @(negedge clk);
      n++;
    end
    cmd_start = 1'b0;
    chk(n == 4 + w, "R5 start-to-done edges", 32'(n), 32'(4 + w));
    @(negedge clk);
    chk(cmd_done === 1'b0, "R5 single-cycle done", 32'(cmd_done), 32'd0);
    shadow[d] = memval(a);
    check_regs(poke ? "R6/R7 register file" : "R4/R7 register file");
  endtask

  initial begin
    rst_n = 1'b0; cmd_start = 1'b0; cmd_addr = '0; cmd_dst = '0; rd_sel = '0;
    for (int r = 0; r < 8; r++) shadow[r] = 16'h0000;
    repeat (3) @(negedge clk);
    chk(cmd_done === 1'b0 && mem_req === 1'b0, "R1 reset outputs",
        {30'd0, cmd_done, mem_req}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_done === 1'b0 && mem_req === 1'b0, "R1 after release",
        {30'd0, cmd_done, mem_req}, 32'd0);
    check_regs("R1 registers cleared");

    // R8: read port follows rd_sel with no clock
    run_load(3, 1, 2, 1'b0);          // 32 into register 1 (R4)
    rd_sel = 3'd1; #1;
    chk(rd_data === 16'd32, "R8 comb read", 32'(rd_data), 32'd32);
    rd_sel = 3'd0; #1;
    chk(rd_data === 16'd0, "R8 comb read", 32'(rd_data), 32'd0);

    run_load(255, 7, 1, 1'b0);        // R4 all-ones
    run_load(128, 7, 3, 1'b0);        // R4 zero overwrites all-ones

    // R3/R4/R5/R6 sweep: latency x destination
    for (int lat = 0; lat <= 6; lat++) begin
      for (int d = 0; d < 8; d++) begin
        run_load((d * 37 + lat * 11) & 255, d, lat, ((d + lat) % 3) == 0);
      end
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule